// File: doc/BRIEF.md
# Ring-Checked Translation Buffer with Autorefill

This block translates a 32-bit virtual address through a small set-associative translation buffer. Each entry holds a virtual page number, an 8-bit address-space tag, a physical page number and a 4-bit attribute. A way hits when its page number matches the request and its tag is nonzero. The tag of the hit entry is looked up in a 32-bit ring register to get a privilege ring. The ring and the attribute are then checked against the requester's privilege index and access type. The result is either a physical address with page size and access rights, or a cause code.

On a miss, the block can refill itself from a one-level page table. It forms the address of the table entry from a table base input and the missing address. It translates that address through the buffer itself at ring 0 as a load, then reads the 32-bit table entry over a simple request/acknowledge memory port. It writes the entry into a way picked by a rolling counter and reports the translation of the original request. A separate write port lets software place or invalidate entries directly.

Requests are accepted one at a time while `req_ready` is high. Each request produces exactly one single-cycle response.

Top module: `ring_tlb`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. Every entry is invalid (tag 0), the ring register holds 0x04030201 (byte i is the tag of ring i), and the refill counter is 0.
- R2: A way hits when its stored page number equals vaddr[31:12] and its tag is nonzero; the set is vaddr[13:12]. A successful translation returns `rsp_paddr` = {entry page, vaddr[11:0]} and `rsp_size` = 4096. On a fault both are 0.
- R3: `rsp_rights` is {exec, write, read}, and is 0 on a fault. For attribute a < 12, read = 1, write = a[0] and exec = a[1]. Attribute 13 gives read and write. Every other attribute gives nothing.
- R4: Access type 0 is a load and needs read, 1 is a store and needs write, and 2 is a fetch and needs exec. A denied access faults with cause 28 (load), 29 (store) or 20 (fetch).
- R5: The ring of a hit is the lowest byte index i of the ring register whose byte equals the entry tag; ring 3 if no byte matches. A ring lower than `req_priv` faults with cause 26 (load/store) or 18 (fetch). This check comes before the attribute check.
- R6: Two or more hits fault with cause 25 (load/store) or 17 (fetch). A miss that is not refilled faults with cause 24 (load/store) or 16 (fetch).
- R7: A miss is never refilled when `req_priv` is 0 and vaddr[31:22] equals `pte_base`[31:22]. It faults with the miss cause and issues no memory read.
- R8: The table-entry address is (`pte_base` | vaddr>>10) with bits [1:0] cleared. It is translated through the buffer as a ring-0 load. If that translation does not give exactly one readable hit, the original miss cause is reported and no memory read is issued.
- R9: `mem_req` is held with a stable, word-aligned `mem_addr` until `mem_ack`. The response appears in the cycle after the acknowledge.
- R10: A refill advances the counter, wraps it modulo the way count, and writes way = new counter value in set vaddr[13:12]. The entry's page comes from vaddr[31:12], its physical page from pte[31:12], its attribute from pte[3:0], and its tag from ring-register byte pte[5:4]. The response is checked using ring pte[5:4]. A later lookup of that page hits with no memory read.
- R11: Writing the ring register replaces the tag-to-ring mapping for all later lookups.
- R12: A request is accepted only while `req_ready` is 1. `req_ready` drops in the cycle after acceptance, and every response is a one-cycle pulse.
- R13: A software write stores the given fields in the given way at set vpn[1:0]. Writing tag 0 invalidates that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege index |
| pte_base | input | 32 | Page-table window base |
| ring_we | input | 1 | Ring register write strobe |
| ring_wdata | input | 32 | New ring register value |
| sw_we | input | 1 | Software entry write strobe |
| sw_way | input | 2 | Way to write |
| sw_vpn | input | 20 | Virtual page number (low bits pick the set) |
| sw_asid | input | 8 | Tag, 0 invalidates |
| sw_ppn | input | 20 | Physical page number |
| sw_attr | input | 4 | Attribute |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | 32 | Physical address of the table entry |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Table entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 6 | Cause code on a fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_size | output | 32 | Page size in bytes |
| rsp_rights | output | 3 | {exec, write, read} |

## Verification
The assertions assume that `mem_ack` comes only while `mem_req` is high, and that software and refill writes never land in the same cycle. They also assume that `req_acc` takes only the values 0 to 2. The stimulus keeps to these rules in three ways. The memory responder acknowledges only an outstanding read, after a chosen delay. Software writes are issued only between lookups, when the block is idle. Access types are swept over 0, 1 and 2 alone. Expected results come from a shadow copy of the buffer that the bench keeps. The bench updates that copy on its own software writes and on the refills it predicts.

// File: rtl/ring_tlb_pkg.sv
package ring_tlb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_PTCHK, ST_MEMRD} tlb_state_e;

  localparam logic [5:0] CS_I_MISS    = 6'd16;
  localparam logic [5:0] CS_I_MULTI   = 6'd17;
  localparam logic [5:0] CS_I_PRIV    = 6'd18;
  localparam logic [5:0] CS_I_PROHIB  = 6'd20;
  localparam logic [5:0] CS_D_MISS    = 6'd24;
  localparam logic [5:0] CS_D_MULTI   = 6'd25;
  localparam logic [5:0] CS_D_PRIV    = 6'd26;
  localparam logic [5:0] CS_LD_PROHIB = 6'd28;
  localparam logic [5:0] CS_ST_PROHIB = 6'd29;

  // {exec, write, read}
  function automatic logic [2:0] attr_rights(input logic [3:0] a);
    if (a < 4'd12)       return {a[1], a[0], 1'b1};
    else if (a == 4'd13) return 3'b011;
    else                 return 3'b000;
  endfunction

  function automatic logic access_ok(input logic [2:0] r, input logic [1:0] acc);
    if (acc == 2'd1)      return r[1];
    else if (acc == 2'd2) return r[2];
    else                  return r[0];
  endfunction

  function automatic logic [5:0] miss_cause(input logic [1:0] acc);
    return (acc == 2'd2) ? CS_I_MISS : CS_D_MISS;
  endfunction

  function automatic logic [5:0] multi_cause(input logic [1:0] acc);
    return (acc == 2'd2) ? CS_I_MULTI : CS_D_MULTI;
  endfunction

  function automatic logic [5:0] priv_cause(input logic [1:0] acc);
    return (acc == 2'd2) ? CS_I_PRIV : CS_D_PRIV;
  endfunction

  function automatic logic [5:0] prohib_cause(input logic [1:0] acc);
    if (acc == 2'd1)      return CS_ST_PROHIB;
    else if (acc == 2'd2) return CS_I_PROHIB;
    else                  return CS_LD_PROHIB;
  endfunction

endpackage

// File: rtl/ring_tlb_way.sv
module ring_tlb_way #(
  parameter int VPN_W    = 20,
  parameter int SET_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [VPN_W-1:0]    wtag,
  input  logic [7:0]          wasid,
  input  logic [VPN_W-1:0]    wppn,
  input  logic [3:0]          wattr,
  input  logic [SET_BITS-1:0] ridx,
  output logic [VPN_W-1:0]    rtag,
  output logic [7:0]          rasid,
  output logic [VPN_W-1:0]    rppn,
  output logic [3:0]          rattr
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int ENT_W = 2 * VPN_W + 12;

  logic [ENT_W-1:0]    mem [SETS];
  logic [SETS-1:0]     written;
  logic [ENT_W-1:0]    rd_q;
  logic                rd_vld;
  logic [SET_BITS-1:0] widx;

  assign widx = wtag[SET_BITS-1:0];

  // Data array: no reset, simple dual port, registered read.
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {wtag, wasid, wppn, wattr};
    rd_q <= mem[ridx];
  end

  // Per-entry written flags give the all-invalid state after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      rd_vld  <= 1'b0;
    end else begin
      if (we) written[widx] <= 1'b1;
      rd_vld <= written[ridx];
    end
  end

  assign rtag  = rd_q[ENT_W-1 -: VPN_W];
  assign rasid = rd_vld ? rd_q[VPN_W+11 -: 8] : 8'd0;
  assign rppn  = rd_q[VPN_W+3 -: VPN_W];
  assign rattr = rd_q[3:0];
endmodule

// File: rtl/ring_tlb_ringmap.sv
module ring_tlb_ringmap (
  input  logic [31:0] ring_reg,
  input  logic [7:0]  asid,
  output logic [1:0]  ring
);
  always_comb begin
    ring = 2'd3;
    for (int i = 3; i >= 0; i--) begin
      if (ring_reg[8*i +: 8] == asid) ring = 2'(i);
    end
  end
endmodule

// File: rtl/ring_tlb.sv
module ring_tlb
  import ring_tlb_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int SET_BITS  = 2,
  parameter int NWAYS     = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [31:0]                    req_vaddr,
  input  logic [1:0]                     req_acc,
  input  logic [1:0]                     req_priv,
  input  logic [31:0]                    pte_base,
  input  logic                           ring_we,
  input  logic [31:0]                    ring_wdata,
  input  logic                           sw_we,
  input  logic [$clog2(NWAYS)-1:0]       sw_way,
  input  logic [31-PAGE_BITS:0]          sw_vpn,
  input  logic [7:0]                     sw_asid,
  input  logic [31-PAGE_BITS:0]          sw_ppn,
  input  logic [3:0]                     sw_attr,
  output logic                           mem_req,
  output logic [31:0]                    mem_addr,
  input  logic                           mem_ack,
  input  logic [31:0]                    mem_rdata,
  output logic                           rsp_valid,
  output logic                           rsp_fault,
  output logic [5:0]                     rsp_cause,
  output logic [31:0]                    rsp_paddr,
  output logic [31:0]                    rsp_size,
  output logic [2:0]                     rsp_rights
);
  localparam int          VPN_W     = 32 - PAGE_BITS;
  localparam int          WAY_W     = $clog2(NWAYS);
  localparam int          WIN_LO    = 22;
  localparam logic [31:0] PAGE_SIZE = 32'd1 << PAGE_BITS;

  tlb_state_e          state;
  logic [31:0]         va_q, pte_q;
  logic [1:0]          acc_q, priv_q;
  logic [31:0]         ring_q;
  logic [WAY_W-1:0]    refill_cnt, nxt_way;

  logic [SET_BITS-1:0] rd_idx;
  logic [31:0]         pte_addr_c;
  logic [VPN_W-1:0]    cmp_vpn;
  logic [NWAYS-1:0]    hit, way_we;
  logic [VPN_W-1:0]    rd_tag [NWAYS];
  logic [7:0]          rd_asid [NWAYS];
  logic [VPN_W-1:0]    rd_ppn [NWAYS];
  logic [3:0]          rd_attr [NWAYS];
  logic [7:0]          sel_asid;
  logic [VPN_W-1:0]    sel_ppn;
  logic [3:0]          sel_attr;
  logic [1:0]          hit_ring;

  logic                refill_wr;
  logic [VPN_W-1:0]    wr_tag, wr_ppn;
  logic [7:0]          wr_asid;
  logic [3:0]          wr_attr;

  logic                fin, r_fault;
  logic [5:0]          r_cause;
  logic [2:0]          r_rights;
  logic [VPN_W-1:0]    r_ppn;
  logic [1:0]          chk_ring;
  logic [3:0]          chk_attr;
  logic                one_hit, no_hit, in_window, pte_ok;
  logic                unused_pte_bits;

  assign req_ready       = (state == ST_IDLE);
  assign pte_addr_c      = (pte_base | (va_q >> 10)) & ~32'h3;
  assign rd_idx          = (state == ST_LOOK) ? pte_addr_c[PAGE_BITS +: SET_BITS]
                                              : req_vaddr[PAGE_BITS +: SET_BITS];
  assign cmp_vpn         = (state == ST_PTCHK) ? pte_q[31:PAGE_BITS] : va_q[31:PAGE_BITS];
  assign in_window       = (priv_q == 2'd0) && (va_q[31:WIN_LO] == pte_base[31:WIN_LO]);
  assign unused_pte_bits = ^mem_rdata[PAGE_BITS-1:6];

  // Write port shared by refill and software writes; refill has priority.
  assign refill_wr = (state == ST_MEMRD) && mem_ack;
  assign nxt_way   = refill_cnt + 1'b1;
  assign wr_tag    = refill_wr ? va_q[31:PAGE_BITS]      : sw_vpn;
  assign wr_ppn    = refill_wr ? mem_rdata[31:PAGE_BITS] : sw_ppn;
  assign wr_attr   = refill_wr ? mem_rdata[3:0]          : sw_attr;
  assign wr_asid   = refill_wr ? ring_q[8*mem_rdata[5:4] +: 8] : sw_asid;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign way_we[w] = refill_wr ? (nxt_way == WAY_W'(w))
                                 : (sw_we && (sw_way == WAY_W'(w)));
    assign hit[w]    = (rd_asid[w] != 8'd0) && (rd_tag[w] == cmp_vpn);

    ring_tlb_way #(.VPN_W(VPN_W), .SET_BITS(SET_BITS)) u_way (
      .clk  (clk),
      .rst  (rst),
      .we   (way_we[w]),
      .wtag (wr_tag),
      .wasid(wr_asid),
      .wppn (wr_ppn),
      .wattr(wr_attr),
      .ridx (rd_idx),
      .rtag (rd_tag[w]),
      .rasid(rd_asid[w]),
      .rppn (rd_ppn[w]),
      .rattr(rd_attr[w])
    );
  end

  always_comb begin
    sel_asid = '0;
    sel_ppn  = '0;
    sel_attr = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (hit[w]) begin
        sel_asid = sel_asid | rd_asid[w];
        sel_ppn  = sel_ppn  | rd_ppn[w];
        sel_attr = sel_attr | rd_attr[w];
      end
    end
  end

  ring_tlb_ringmap u_ringmap (.ring_reg(ring_q), .asid(sel_asid), .ring(hit_ring));

  assign one_hit = $onehot(hit);
  assign no_hit  = (hit == '0);
  assign pte_ok  = one_hit && sel_attr_readable(sel_attr);

  function automatic logic sel_attr_readable(input logic [3:0] a);
    logic [2:0] r;
    r = attr_rights(a);
    return r[0];
  endfunction

  // Result of the current state, registered below when fin is set.
  always_comb begin
    chk_ring = (state == ST_MEMRD) ? mem_rdata[5:4] : hit_ring;
    chk_attr = (state == ST_MEMRD) ? mem_rdata[3:0] : sel_attr;
    r_ppn    = (state == ST_MEMRD) ? mem_rdata[31:PAGE_BITS] : sel_ppn;
    r_rights = attr_rights(chk_attr);
    r_fault  = 1'b1;
    if (chk_ring < priv_q)                r_cause = priv_cause(acc_q);
    else if (!access_ok(r_rights, acc_q)) r_cause = prohib_cause(acc_q);
    else begin
      r_cause = 6'd0;
      r_fault = 1'b0;
    end
    fin = 1'b0;
    unique case (state)
      ST_LOOK: begin
        fin = 1'b1;
        if (no_hit) begin
          r_fault = 1'b1;
          r_cause = miss_cause(acc_q);
          fin     = in_window;
        end else if (!one_hit) begin
          r_fault = 1'b1;
          r_cause = multi_cause(acc_q);
        end
      end
      ST_PTCHK: begin
        fin     = !pte_ok;
        r_fault = 1'b1;
        r_cause = miss_cause(acc_q);
      end
      ST_MEMRD: fin = mem_ack;
      default:  fin = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= 32'h0403_0201;
    else if (ring_we) ring_q <= ring_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      va_q       <= '0;
      pte_q      <= '0;
      acc_q      <= '0;
      priv_q     <= '0;
      refill_cnt <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_cause  <= '0;
      rsp_paddr  <= '0;
      rsp_size   <= '0;
      rsp_rights <= '0;
    end else begin
      rsp_valid <= fin;
      if (fin) begin
        rsp_fault  <= r_fault;
        rsp_cause  <= r_cause;
        rsp_paddr  <= r_fault ? 32'd0 : {r_ppn, va_q[PAGE_BITS-1:0]};
        rsp_size   <= r_fault ? 32'd0 : PAGE_SIZE;
        rsp_rights <= r_fault ? 3'd0  : r_rights;
      end
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          priv_q <= req_priv;
          state  <= ST_LOOK;
        end
        ST_LOOK: if (fin) state <= ST_IDLE;
                 else begin
                   pte_q <= pte_addr_c;
                   state <= ST_PTCHK;
                 end
        ST_PTCHK: if (fin) state <= ST_IDLE;
                  else begin
                    mem_req  <= 1'b1;
                    mem_addr <= {sel_ppn, pte_q[PAGE_BITS-1:0]};
                    state    <= ST_MEMRD;
                  end
        ST_MEMRD: if (mem_ack) begin
          mem_req    <= 1'b0;
          refill_cnt <= nxt_way;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_tlb_chk.sv
module ring_tlb_chk #(
  parameter int PAGE_BITS = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_acc,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_size,
  input logic [2:0]  rsp_rights
);
  logic [1:0] acc_seen;

  always_ff @(posedge clk) begin
    if (rst) acc_seen <= 2'd0;
    else if (req_valid && req_ready) acc_seen <= req_acc;
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);                                       // R12
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);                          // R12
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));           // R9
  AST_MEM_DONE: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req && rsp_valid);                   // R9
  AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);                             // R8
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);                                         // R9
  AST_PAGE_SIZE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_size == (32'd1 << PAGE_BITS));   // R2
  AST_RIGHT_GRANTED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |->
      ((acc_seen == 2'd1) ? rsp_rights[1] :
       (acc_seen == 2'd2) ? rsp_rights[2] : rsp_rights[0]));         // R4
endmodule

bind ring_tlb ring_tlb_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_acc   (req_acc),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_size  (rsp_size),
  .rsp_rights(rsp_rights)
);

// File: tb/ring_tlb_tb_top.sv
module ring_tlb_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_acc = 0;
  logic [1:0]  req_priv = 0;
  logic [31:0] pte_base = 32'h8000_0000;
  logic        ring_we = 0;
  logic [31:0] ring_wdata = 0;
  logic        sw_we = 0;
  logic [1:0]  sw_way = 0;
  logic [19:0] sw_vpn = 0;
  logic [7:0]  sw_asid = 0;
  logic [19:0] sw_ppn = 0;
  logic [3:0]  sw_attr = 0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic        rsp_valid, rsp_fault;
  logic [5:0]  rsp_cause;
  logic [31:0] rsp_paddr, rsp_size;
  logic [2:0]  rsp_rights;

  always #5 clk = ~clk;

  ring_tlb dut_i (.*);

  int vectors = 0, fails = 0;
  bit finished = 0;

  // shadow model
  logic [19:0] m_vpn [4][4];
  logic [7:0]  m_asid [4][4];
  logic [19:0] m_ppn [4][4];
  logic [3:0]  m_attr [4][4];
  logic [31:0] m_ring = 32'h0403_0201;
  int          m_cnt = 0;

  // memory responder
  logic [1:0]  pte_ring = 1;
  logic [3:0]  pte_attr = 1;
  int          ack_delay = 0;
  int          mem_reads = 0;
  logic [31:0] last_maddr = 0;

  function automatic logic [31:0] pte_of(input logic [31:0] va);
    return {va[31:12] ^ 20'h5A5A5, 6'd0, pte_ring, pte_attr};
  endfunction

  function automatic logic [2:0] m_rights(input logic [3:0] a);
    if (a < 12) return {a[1], a[0], 1'b1};
    if (a == 13) return 3'b011;
    return 3'b000;
  endfunction

  function automatic logic [1:0] m_ring_of(input logic [7:0] asid);
    logic [1:0] r = 3;
    for (int i = 3; i >= 0; i--) if (m_ring[8*i +: 8] == asid) r = 2'(i);
    return r;
  endfunction

  function automatic int m_hits(input logic [31:0] va, output int hw);
    int n = 0;
    hw = 0;
    for (int w = 0; w < 4; w++)
      if (m_asid[w][va[13:12]] != 0 && m_vpn[w][va[13:12]] == va[31:12]) begin
        n++;
        hw = w;
      end
    return n;
  endfunction

  task automatic m_eval(input logic [1:0] ring, input logic [3:0] attr, input logic [19:0] ppn,
                        input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv,
                        output bit f, output logic [5:0] c, output logic [31:0] pa,
                        output logic [2:0] rt);
    logic [2:0] r = m_rights(attr);
    bit ok = (acc == 1) ? r[1] : (acc == 2) ? r[2] : r[0];
    f = 1; pa = 0; rt = 0;
    if (ring < priv) c = (acc == 2) ? 6'd18 : 6'd26;
    else if (!ok) c = (acc == 0) ? 6'd28 : (acc == 1) ? 6'd29 : 6'd20;
    else begin
      f = 0; c = 0; pa = {ppn, va[11:0]}; rt = r;
    end
  endtask

  task automatic sw_write(input int way, input logic [19:0] vpn, input logic [7:0] asid,
                          input logic [19:0] ppn, input logic [3:0] attr);
    @(negedge clk);
    sw_we = 1; sw_way = 2'(way); sw_vpn = vpn; sw_asid = asid; sw_ppn = ppn; sw_attr = attr;
    @(negedge clk);
    sw_we = 0;
    m_vpn[way][vpn[1:0]] = vpn; m_asid[way][vpn[1:0]] = asid;
    m_ppn[way][vpn[1:0]] = ppn; m_attr[way][vpn[1:0]] = attr;
  endtask

  task automatic ring_write(input logic [31:0] v);
    @(negedge clk);
    ring_we = 1; ring_wdata = v;
    @(negedge clk);
    ring_we = 0;
    m_ring = v;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv,
                        input string req);
    int hw, n, hw2, reads0, wait_n;
    bit ef, exp_mem, got;
    logic [5:0] ec;
    logic [31:0] epa, emaddr, pa_pte, pte;
    logic [2:0] ert;
    exp_mem = 0; emaddr = 0;
    n = m_hits(va, hw);
    if (n > 1) begin
      ef = 1; ec = (acc == 2) ? 6'd17 : 6'd25; epa = 0; ert = 0;
    end else if (n == 1) begin
      m_eval(m_ring_of(m_asid[hw][va[13:12]]), m_attr[hw][va[13:12]], m_ppn[hw][va[13:12]],
             va, acc, priv, ef, ec, epa, ert);
    end else begin
      ef = 1; ec = (acc == 2) ? 6'd16 : 6'd24; epa = 0; ert = 0;
      if (!(priv == 0 && va[31:22] == pte_base[31:22])) begin
        pa_pte = (pte_base | (va >> 10)) & ~32'h3;
        if (m_hits(pa_pte, hw2) == 1 && m_rights(m_attr[hw2][pa_pte[13:12]])[0]) begin
          exp_mem = 1;
          emaddr = {m_ppn[hw2][pa_pte[13:12]], pa_pte[11:0]};
          pte = pte_of(va);
          m_cnt = (m_cnt + 1) % 4;
          m_vpn[m_cnt][va[13:12]]  = va[31:12];
          m_asid[m_cnt][va[13:12]] = m_ring[8*pte[5:4] +: 8];
          m_ppn[m_cnt][va[13:12]]  = pte[31:12];
          m_attr[m_cnt][va[13:12]] = pte[3:0];
          m_eval(pte[5:4], pte[3:0], pte[31:12], va, acc, priv, ef, ec, epa, ert);
        end
      end
    end
    reads0 = mem_reads;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
    got = 0;
    for (wait_n = 0; wait_n < 100; wait_n++) begin
      if (rsp_valid) begin got = 1; break; end
      @(negedge clk);
    end
    vectors++;
    if (!got) begin
      fails++;
      $display("FAIL %s va=%h: no response (act none, exp response)", req, va);
    end else if (rsp_fault !== ef || rsp_cause !== ec || rsp_paddr !== epa ||
                 rsp_rights !== ert || rsp_size !== (ef ? 32'd0 : 32'd4096) ||
                 (mem_reads - reads0) != int'(exp_mem) || (exp_mem && last_maddr !== emaddr)) begin
      fails++;
      $display("FAIL %s va=%h acc=%0d priv=%0d: act f=%0d c=%0d pa=%h rt=%b sz=%0d rd=%0d ma=%h exp f=%0d c=%0d pa=%h rt=%b rd=%0d ma=%h",
               req, va, acc, priv, rsp_fault, rsp_cause, rsp_paddr, rsp_rights, rsp_size,
               mem_reads - reads0, last_maddr, ef, ec, epa, ert, exp_mem, emaddr);
    end
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        cnt++;
        if (cnt > ack_delay) begin
          mem_ack = 1;
          mem_rdata = pte_of(req_vaddr);
          last_maddr = mem_addr;
          mem_reads++;
          cnt = 0;
        end
      end else cnt = 0;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: act hung, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 4; s++) begin
        m_vpn[w][s] = 0; m_asid[w][s] = 0; m_ppn[w][s] = 0; m_attr[w][s] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    vectors++;
    if (req_ready !== 1 || rsp_valid !== 0 || mem_req !== 0) begin
      fails++;
      $display("FAIL R1 reset: act rdy=%b rv=%b mr=%b exp 1 0 0", req_ready, rsp_valid, mem_req);
    end
    lookup(32'h8000_1000, 0, 0, "R1");
    lookup(32'h8000_1000, 2, 0, "R1");
    // R2 R3 R4: attribute by access sweep
    for (int a = 0; a < 16; a++) begin
      sw_write(0, 20'h01000, 8'd1, 20'hABC00 + 20'(a), 4'(a));
      for (int acc = 0; acc < 3; acc++) lookup(32'h0100_0234 + 32'(a), 2'(acc), 0, "R3_R4");
    end
    // R5 ring mapping
    foreach (m_ring[i]) ; // no-op keep structure simple
    begin
      logic [7:0] tags [5] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd9};
      for (int t = 0; t < 5; t++) begin
        sw_write(1, 20'h02001, tags[t], 20'h00777, 4'd13);
        for (int p = 0; p < 4; p++) begin
          lookup(32'h0200_1ABC, 0, 2'(p), "R5");
          lookup(32'h0200_1ABC, 2, 2'(p), "R5");
        end
      end
    end
    // R11 ring register rewrite
    ring_write(32'h0705_0502);
    begin
      logic [7:0] tags2 [4] = '{8'd1, 8'd2, 8'd5, 8'd7};
      for (int t = 0; t < 4; t++) begin
        sw_write(1, 20'h02001, tags2[t], 20'h00777, 4'd13);
        for (int p = 0; p < 4; p++) lookup(32'h0200_1ABC, 0, 2'(p), "R11");
      end
    end
    ring_write(32'h0403_0201);
    // R6 multi-hit, R13 invalidation, R8 unmapped table page
    sw_write(2, 20'h03002, 8'd1, 20'h11111, 4'd0);
    sw_write(3, 20'h03002, 8'd1, 20'h22222, 4'd0);
    lookup(32'h0300_2010, 0, 0, "R6");
    lookup(32'h0300_2010, 2, 0, "R6");
    sw_write(3, 20'h03002, 8'd0, 20'h22222, 4'd0);
    lookup(32'h0300_2010, 0, 0, "R13");
    sw_write(2, 20'h03002, 8'd0, 20'h11111, 4'd0);
    lookup(32'h0300_2010, 0, 0, "R8");
    // R8 R9 R10 refill through mapped table page
    sw_write(0, 20'h80000, 8'd1, 20'h0C000, 4'd0);
    pte_ring = 1; pte_attr = 1;
    for (int k = 1; k < 24; k += 4) begin
      ack_delay = k % 4;
      lookup({20'(k), 12'h048}, 1, 1, "R10");
    end
    for (int k = 1; k < 24; k += 4) lookup({20'(k), 12'h0F0}, 0, 1, "R10");
    pte_ring = 0;
    lookup({20'd25, 12'h000}, 0, 2, "R10_R5");
    pte_ring = 1;
    lookup({20'd29, 12'h000}, 2, 1, "R9_R4");
    // R7 window suppression versus refill outside ring 0
    sw_write(1, 20'h80200, 8'd1, 20'h0D000, 4'd0);
    lookup(32'h8000_1000, 0, 0, "R7");
    lookup(32'h8000_1000, 0, 1, "R7");
    lookup(32'h8000_1000, 1, 1, "R7");
    // R8 table page not readable
    sw_write(0, 20'h80000, 8'd1, 20'h0C000, 4'd15);
    lookup({20'd33, 12'h000}, 0, 1, "R8");
    // R12 back-to-back requests accepted only when ready
    lookup(32'h8000_1000, 0, 2, "R12");
    lookup(32'h8000_1000, 0, 2, "R12");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule